// File: doc/BRIEF.md
# I2C-over-AUX EDID Responder

This block answers display-identification (EDID) reads that arrive as I2C transactions wrapped in auxiliary-channel requests. A host sees two 32-bit registers: a control register and a data register. The host puts a request word into the data register, then writes the control register with the send-busy bit set. The block decodes the request in that same cycle. It updates its EDID session, which covers target selection, the read pointer and the error flag. It then posts a reply word into the data register and a reply size into the control register. Both are visible on the next cycle.

Address-only messages only open, re-open or close the session. The EDID byte store sits outside the block. It is addressed through `edid_addr_o` and `edid_port_o` and returns its byte combinationally on `edid_byte_i`. Each port also supplies a monitor-present flag and a packet-port flag, which decide whether EDID data is available. Every request completes at once with an acknowledge, and any I2C write payload is dropped.

Top module: `aux_edid_resp`

## Requirements
- R1: After reset, the control and data registers read 0, `err_o` is 0 and `edid_addr_o` is 0.
- R2: A control write with bit 31 (send-busy) clear is stored verbatim, and no transaction happens: the data register and the read pointer keep their values.
- R3: A control write with bit 31 set reads back one cycle later as the written value with bit 31 cleared and with the size field [24:20] replaced. The size is 2 when bit 0 of the request's control byte (data[24], 1 = read) is set, and 1 otherwise.
- R4: The request word is decoded as control byte = data[31:24] and target address = data[23:8], with message length = control[24:20]. A length-3 message with the continue bit (control byte bit 2, data[26]) clear is a stop. A stop deselects the target, clears the availability flag, the read pointer and `err_o`.
- R5: A length-3 message with the continue bit set and address 0x0050 selects the EDID target. It records `port_idx_i` on `edid_port_o`. It marks data available only if that port's `monitor_i` and `pkt_port_i` bits are both 1.
- R6: A length-3 message with the continue bit set and address 0 resets the session in the same way as a stop.
- R7: A read (bit 0 = 1) with length 4, while the target is selected and available, replies {ACK_CODE, byte, 16'h0}. The byte is the store byte at the read pointer, and the pointer then advances by one.
- R8: When the read pointer has reached EDID_BYTES, a valid read returns byte 0x00, leaves the pointer in place and sets `err_o`.
- R9: A length-4 read while the target is not selected or not available returns byte 0xFF and leaves the pointer unchanged.
- R10: A write operation (bit 0 = 0) with a length other than 3 replies {ACK_CODE, 8'h00, 16'h0} and leaves the session unchanged.
- R11: A read operation with a length other than 3 or 4 posts no reply: the data register keeps the request word and the session is unchanged. The control register still gets R3's treatment.
- R12: A host write to the data register is stored verbatim and reads back on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control, 1 data |
| wr_data_i | input | 32 | Write value |
| port_idx_i | input | PORT_W | Port index that owns this channel |
| monitor_i | input | PORTS | Monitor-present flag per port |
| pkt_port_i | input | PORTS | Packet-based-port flag per port |
| edid_byte_i | input | 8 | Store byte at `edid_addr_o` for `edid_port_o` |
| ctrl_o | output | 32 | Control register readback |
| data_o | output | 32 | Data register readback (request or reply) |
| edid_addr_o | output | ADDR_W | Read pointer into the EDID store |
| edid_port_o | output | PORT_W | Port recorded at target selection |
| err_o | output | 1 | Read past the end of the EDID store |

## Verification
The assertions assume that a host never writes a register on the same cycle that a reply is posted. This holds because a reply is caused only by a host write, and the port takes one write per cycle. They also assume that `monitor_i`, `pkt_port_i` and `port_idx_i` are stable around a selection, and that `edid_byte_i` depends only on the address and port outputs. The stimulus writes the request word one cycle and the control word the next. It changes port flags only between sessions, and it models the store as a fixed function of the pointer.

// File: rtl/aux_edid_pkg.sv
package aux_edid_pkg;
  localparam int CTL_BUSY_BIT = 31;
  localparam int CTL_LEN_LSB  = 20;
  localparam int CTL_LEN_W    = 5;
  localparam logic [15:0] EDID_TARGET = 16'h0050;
  localparam int OP_RD_BIT  = 0;
  localparam int OP_MOT_BIT = 2;

  typedef enum logic [2:0] {
    REQ_NONE,
    REQ_STOP,
    REQ_CLEAR,
    REQ_SELECT,
    REQ_ADDR_OTHER,
    REQ_READ,
    REQ_BAD_READ,
    REQ_WRITE
  } req_kind_e;
endpackage

// File: rtl/aux_req_decode.sv
module aux_req_decode
  import aux_edid_pkg::*;
(
  input  logic        fire_i,
  input  logic [31:0] ctrl_wdata_i,
  input  logic [31:0] req_word_i,
  output req_kind_e   kind_o
);
  logic [CTL_LEN_W-1:0] len;
  logic [7:0]           op;
  logic [15:0]          addr;

  assign len  = ctrl_wdata_i[CTL_LEN_LSB +: CTL_LEN_W];
  assign op   = req_word_i[31:24];
  assign addr = req_word_i[23:8];

  always_comb begin
    kind_o = REQ_NONE;
    if (fire_i) begin
      if (len == CTL_LEN_W'(3)) begin
        if (!op[OP_MOT_BIT])         kind_o = REQ_STOP;
        else if (addr == 16'h0000)   kind_o = REQ_CLEAR;
        else if (addr == EDID_TARGET) kind_o = REQ_SELECT;
        else                         kind_o = REQ_ADDR_OTHER;
      end else if (!op[OP_RD_BIT]) begin
        kind_o = REQ_WRITE;
      end else if (len == CTL_LEN_W'(4)) begin
        kind_o = REQ_READ;
      end else begin
        kind_o = REQ_BAD_READ;
      end
    end
  end
endmodule

// File: rtl/aux_edid_session.sv
module aux_edid_session
  import aux_edid_pkg::*;
#(
  parameter int EDID_BYTES = 128,
  parameter int PORTS      = 4,
  localparam int ADDR_W    = $clog2(EDID_BYTES),
  localparam int PTR_W     = ADDR_W + 1,
  localparam int PORT_W    = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  req_kind_e         kind_i,
  input  logic [PORT_W-1:0] port_idx_i,
  input  logic [PORTS-1:0]  monitor_i,
  input  logic [PORTS-1:0]  pkt_port_i,
  input  logic [7:0]        edid_byte_i,
  output logic [7:0]        rd_byte_o,
  output logic [ADDR_W-1:0] edid_addr_o,
  output logic [PORT_W-1:0] edid_port_o,
  output logic              err_o
);
  localparam logic [PTR_W-1:0] PTR_LIMIT = PTR_W'(EDID_BYTES);

  logic             sel_q, avail_q, err_q;
  logic [PTR_W-1:0] ptr_q;
  logic [PORT_W-1:0] port_q;
  logic             in_range, live;

  assign in_range = ptr_q < PTR_LIMIT;
  assign live     = sel_q && avail_q;

  always_comb begin
    if (!live)         rd_byte_o = 8'hFF;
    else if (in_range) rd_byte_o = edid_byte_i;
    else               rd_byte_o = 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      avail_q <= 1'b0;
      err_q   <= 1'b0;
      ptr_q   <= '0;
      port_q  <= '0;
    end else begin
      unique case (kind_i)
        REQ_STOP, REQ_CLEAR: begin
          sel_q   <= 1'b0;
          avail_q <= 1'b0;
          err_q   <= 1'b0;
          ptr_q   <= '0;
          port_q  <= '0;
        end
        REQ_SELECT: begin
          sel_q   <= 1'b1;
          port_q  <= port_idx_i;
          avail_q <= monitor_i[port_idx_i] & pkt_port_i[port_idx_i];
        end
        REQ_READ: begin
          if (live) begin
            if (in_range) ptr_q <= ptr_q + PTR_W'(1);
            else          err_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign edid_addr_o = ptr_q[ADDR_W-1:0];
  assign edid_port_o = port_q;
  assign err_o       = err_q;

  AST_PTR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PTR_LIMIT); // R8
  AST_STOP_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == REQ_STOP) |=> (!sel_q && ptr_q == '0 && !err_q)); // R4
  AST_CLEAR_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == REQ_CLEAR) |=> (!sel_q && ptr_q == '0)); // R6
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == REQ_READ && live && in_range) |=> (ptr_q == $past(ptr_q) + PTR_W'(1))); // R7
  AST_NOSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == REQ_READ && !live) |=> $stable(ptr_q)); // R9
  AST_END_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == REQ_READ && live && !in_range) |=> (err_q && $stable(ptr_q))); // R8
  AST_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == REQ_WRITE) |=> ($stable(ptr_q) && $stable(sel_q))); // R10
endmodule

// File: rtl/aux_ch_regs.sv
module aux_ch_regs
  import aux_edid_pkg::*;
#(
  parameter logic [7:0] ACK_CODE = 8'h00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        wr_sel_i,
  input  logic [31:0] wr_data_i,
  input  req_kind_e   kind_i,
  input  logic [7:0]  rd_byte_i,
  output logic        fire_o,
  output logic [31:0] ctrl_o,
  output logic [31:0] data_o
);
  localparam logic [31:0] LEN_MASK  = ((32'd1 << CTL_LEN_W) - 32'd1) << CTL_LEN_LSB;
  localparam logic [31:0] BUSY_MASK = 32'd1 << CTL_BUSY_BIT;

  logic [31:0] ctrl_q, data_q, reply;
  logic [CTL_LEN_W-1:0] ret_size;
  logic posts_reply;

  assign fire_o      = wr_en_i && !wr_sel_i && wr_data_i[CTL_BUSY_BIT];
  assign ret_size    = data_q[24 + OP_RD_BIT] ? CTL_LEN_W'(2) : CTL_LEN_W'(1);
  assign posts_reply = (kind_i != REQ_NONE) && (kind_i != REQ_BAD_READ);
  assign reply       = {ACK_CODE, (kind_i == REQ_READ) ? rd_byte_i : 8'h00, 16'h0000};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_en_i && !wr_sel_i) begin
      if (fire_o)
        ctrl_q <= (wr_data_i & ~(LEN_MASK | BUSY_MASK)) |
                  (32'(ret_size) << CTL_LEN_LSB);
      else
        ctrl_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  data_q <= '0;
    else if (wr_en_i && wr_sel_i) data_q <= wr_data_i;
    else if (posts_reply)         data_q <= reply;
  end

  assign ctrl_o = ctrl_q;
  assign data_o = data_q;

  AST_BUSY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !ctrl_q[CTL_BUSY_BIT]); // R3
  AST_READ_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && data_q[24]) |=> (ctrl_q[CTL_LEN_LSB +: CTL_LEN_W] == CTL_LEN_W'(2))); // R3
  AST_PLAIN_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i && !wr_data_i[CTL_BUSY_BIT]) |=> (ctrl_q == $past(wr_data_i))); // R2
  AST_BADREAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == REQ_BAD_READ) |=> $stable(data_q)); // R11
  AST_DATA_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i) |=> (data_q == $past(wr_data_i))); // R12
endmodule

// File: rtl/aux_edid_resp.sv
module aux_edid_resp
  import aux_edid_pkg::*;
#(
  parameter int         EDID_BYTES = 128,
  parameter int         PORTS      = 4,
  parameter logic [7:0] ACK_CODE   = 8'h00,
  localparam int        ADDR_W     = $clog2(EDID_BYTES),
  localparam int        PORT_W     = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [31:0]       wr_data_i,
  input  logic [PORT_W-1:0] port_idx_i,
  input  logic [PORTS-1:0]  monitor_i,
  input  logic [PORTS-1:0]  pkt_port_i,
  input  logic [7:0]        edid_byte_i,
  output logic [31:0]       ctrl_o,
  output logic [31:0]       data_o,
  output logic [ADDR_W-1:0] edid_addr_o,
  output logic [PORT_W-1:0] edid_port_o,
  output logic              err_o
);
  logic      fire;
  req_kind_e kind;
  logic [7:0] rd_byte;

  aux_ch_regs #(.ACK_CODE(ACK_CODE)) regs_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .kind_i   (kind),
    .rd_byte_i(rd_byte),
    .fire_o   (fire),
    .ctrl_o, .data_o
  );

  aux_req_decode dec_i (
    .fire_i      (fire),
    .ctrl_wdata_i(wr_data_i),
    .req_word_i  (data_o),
    .kind_o      (kind)
  );

  aux_edid_session #(.EDID_BYTES(EDID_BYTES), .PORTS(PORTS)) sess_i (
    .clk_i, .rst_ni,
    .kind_i     (kind),
    .port_idx_i, .monitor_i, .pkt_port_i, .edid_byte_i,
    .rd_byte_o  (rd_byte),
    .edid_addr_o, .edid_port_o, .err_o
  );
endmodule

// File: tb/aux_edid_resp_tb_top.sv
`timescale 1ns/1ps
module aux_edid_resp_tb_top;
  localparam int NB = 128;
  localparam logic [7:0] OP_RD_C = 8'h05, OP_RD_E = 8'h01, OP_WR_C = 8'h04, OP_WR_E = 8'h00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0] port_idx = 2'd2;
  logic [3:0] monitor = 4'b0100, pkt = 4'b0100;
  logic [7:0] edid_byte;
  logic [31:0] ctrl, data;
  logic [6:0] eaddr;
  logic [1:0] eport;
  logic err;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] byte_at(int a);
    return 8'((a * 37 + 11) & 255) ^ 8'hA5;
  endfunction

  assign edid_byte = byte_at(int'(eaddr));

  aux_edid_resp dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .port_idx_i(port_idx), .monitor_i(monitor), .pkt_port_i(pkt), .edid_byte_i(edid_byte),
    .ctrl_o(ctrl), .data_o(data), .edid_addr_o(eaddr), .edid_port_o(eport), .err_o(err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(logic [7:0] op, logic [15:0] addr, int len);
    wr(1'b1, {op, addr, 8'h00});
    wr(1'b0, 32'h8000_0000 | (32'(len) << 20));
  endtask

  task automatic t_reset;
    chk("R1 ctrl", ctrl, 0);
    chk("R1 data", data, 0);
    chk("R1 err", {31'd0, err}, 0);
    chk("R1 addr", {25'd0, eaddr}, 0);
  endtask

  task automatic t_plain_ctrl;
    wr(1'b1, 32'hCAFE_0123);
    chk("R12 data store", data, 32'hCAFE_0123);
    wr(1'b0, 32'h7ABC_DEF1);
    chk("R2 ctrl verbatim", ctrl, 32'h7ABC_DEF1);
    chk("R2 data untouched", data, 32'hCAFE_0123);
  endtask

  task automatic t_select_read;
    send(OP_WR_C, 16'h0050, 3);
    chk("R3 write size", ctrl, 32'h0010_0000);
    chk("R5 ack reply", data, 0);
    chk("R5 port", {30'd0, eport}, 2);
    for (int i = 0; i < 3; i++) begin
      send(OP_RD_C, 16'h0050, 4);
      chk("R7 reply", data, {8'h00, byte_at(i), 16'h0});
      chk("R3 read size", ctrl, 32'h0020_0000);
    end
    chk("R7 pointer", {25'd0, eaddr}, 3);
  endtask

  task automatic t_stop;
    send(OP_WR_E, 16'h0050, 3);
    chk("R4 ptr cleared", {25'd0, eaddr}, 0);
    send(OP_RD_E, 16'h0050, 4);
    chk("R4 deselected FF", data, {8'h00, 8'hFF, 16'h0});
    chk("R9 ptr held", {25'd0, eaddr}, 0);
  endtask

  task automatic t_not_pkt;
    pkt = 4'b0000;
    send(OP_WR_C, 16'h0050, 3);
    send(OP_RD_C, 16'h0050, 4);
    chk("R5 non-packet port FF", data, {8'h00, 8'hFF, 16'h0});
    chk("R9 ptr held", {25'd0, eaddr}, 0);
    send(OP_WR_E, 16'h0050, 3);
    pkt = 4'b0100;
  endtask

  task automatic t_clear;
    send(OP_WR_C, 16'h0050, 3);
    send(OP_RD_C, 16'h0050, 4);
    chk("R6 pre read", data, {8'h00, byte_at(0), 16'h0});
    send(OP_WR_C, 16'h0000, 3);
    chk("R6 ptr reset", {25'd0, eaddr}, 0);
    send(OP_RD_C, 16'h0050, 4);
    chk("R6 session closed", data, {8'h00, 8'hFF, 16'h0});
  endtask

  task automatic t_write_ignored;
    send(OP_WR_C, 16'h0050, 3);
    send(OP_RD_C, 16'h0050, 4);
    send(OP_WR_C, 16'h0050, 5);
    chk("R10 ack only", data, 0);
    chk("R10 ptr kept", {25'd0, eaddr}, 1);
    send(OP_RD_C, 16'h0050, 4);
    chk("R10 next byte", data, {8'h00, byte_at(1), 16'h0});
  endtask

  task automatic t_bad_read;
    send(OP_RD_C, 16'h0050, 6);
    chk("R11 data kept", data, {OP_RD_C, 16'h0050, 8'h00});
    chk("R11 size", ctrl, 32'h0020_0000);
    chk("R11 ptr kept", {25'd0, eaddr}, 2);
  endtask

  task automatic t_overflow;
    send(OP_WR_E, 16'h0050, 3);
    send(OP_WR_C, 16'h0050, 3);
    for (int i = 0; i < NB; i++) begin
      send(OP_RD_C, 16'h0050, 4);
      if (i == NB - 1) chk("R7 last byte", data, {8'h00, byte_at(NB - 1), 16'h0});
    end
    chk("R8 no err yet", {31'd0, err}, 0);
    send(OP_RD_C, 16'h0050, 4);
    chk("R8 zero byte", data, 0);
    chk("R8 err set", {31'd0, err}, 1);
    send(OP_WR_E, 16'h0050, 3);
    chk("R4 err cleared", {31'd0, err}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_plain_ctrl();
    t_select_read();
    t_stop();
    t_not_pkt();
    t_clear();
    t_write_ignored();
    t_bad_read();
    t_overflow();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule